// File: doc/BRIEF.md
# Multiplexed external memory bus sequencer

This block produces the external bus strobes of an 8-bit microcontroller whose low address byte and data byte share one port. Every clock period of the block is one oscillator period. A free-running phase counter divides time into machine cycles of 12 periods, made of 6 states of 2 periods each. Each machine cycle is split into two 6-period slots.

In an ordinary machine cycle both slots are program fetches. The address latch enable pulses high, the fetch address goes out on the shared port, and the program strobe then goes low to read one code byte. The byte is returned to the core with a one-period valid pulse.

A core model requests an external data access one machine cycle ahead, giving a direction flag, a 16-bit address and a write byte. The block then replaces both fetch slots of the following machine cycle with a single data cycle. That cycle has one address latch pulse and one long read or write strobe. It ends with a done pulse, which carries the read byte for a read.

The sequencer is a state machine clocked alongside the phase counter:
- Fetch states: `ST_F_ALE` (latch pulse), `ST_F_HOLD` (address hold) and `ST_F_CODE` (program strobe low).
- Data states: `ST_D_ALE`, `ST_D_HOLD`, `ST_D_SETUP` (before the strobe), `ST_D_STROBE` (read or write strobe low) and `ST_D_END` (write hold, or bus idle).

The transitions are:
- `ST_F_ALE`→`ST_F_HOLD` at slot period 1.
- `ST_F_HOLD`→`ST_F_CODE` always.
- `ST_F_CODE`→`ST_F_ALE` at slot period 5, or `ST_F_CODE`→`ST_D_ALE` at cycle period 11 when a request is pending.
- `ST_D_ALE`→`ST_D_HOLD` at period 1.
- `ST_D_HOLD`→`ST_D_SETUP` always.
- `ST_D_SETUP`→`ST_D_STROBE` at period 4.
- `ST_D_STROBE`→`ST_D_END` at period 10.
- `ST_D_END`→`ST_F_ALE` always.

Top module: `xbus_seq`

## Requirements
- R1: While reset is held, the address latch enable is high, the program, read and write strobes (all active low) are high, and done and code_valid are low. The first period after reset is period 0 of a machine cycle.
- R2: A machine cycle is 12 periods, numbered 0 to 11, and holds two 6-period slots. In a fetch cycle the address latch enable is high in periods 0–1 and 6–7 and low otherwise, so each pulse is 2 periods wide.
- R3: In a fetch cycle the program strobe is low in periods 3–5 and 9–11. It therefore goes low twice per cycle, 1 period after the latch enable falls, and stays low for 3 periods.
- R4: In each fetch slot the port drives the low fetch-address byte in slot periods 0–2 and floats in periods 3–5. addr_hi carries the high byte for the whole slot. The fetch address is the value of code_addr at the clock edge that starts the slot.
- R5: The port byte present in the last strobe-low period of a fetch slot is presented on code_byte. code_valid is high for exactly the first period after that slot.
- R6: The request is sampled only at the edge ending period 11 of a fetch cycle. When it is high, the next machine cycle is a data cycle. The machine cycle after a data cycle is always a fetch cycle, even if the request is still high.
- R7: A data cycle has a single latch pulse in periods 0–1 and no program strobe.
- R8: For a read (req_we=0), read strobe low in periods 5–10; port drives the low address byte in periods 0–4 and floats in 5–11; port byte of period 10 appears on rdata with done high in period 11.
- R9: For a write (req_we=1), the write strobe is low in periods 5–10. The port drives the low address byte in periods 0–3 and the write byte in periods 4–11. done is high in period 11.
- R10: At most one of the program, read and write strobes is low in any period.
- R11: The direction, address and write byte are captured at the accepting edge. Changing them afterwards has no effect on the ongoing data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-period clock |
| rst | input | 1 | Synchronous reset, active high |
| code_addr | input | 16 | Address of the next program fetch |
| code_byte | output | 8 | Last fetched code byte |
| code_valid | output | 1 | One-period pulse when code_byte is new |
| req | input | 1 | Data access request, held until done |
| req_we | input | 1 | Access direction, 1 = write |
| req_addr | input | 16 | Data access address |
| req_wdata | input | 8 | Write byte |
| done | output | 1 | One-period pulse at the end of a data cycle |
| rdata | output | 8 | Byte captured by the last read |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| addr_hi | output | 8 | High address byte |
| port_out | output | 8 | Shared port drive value |
| port_oe | output | 1 | Shared port output enable |
| port_in | input | 8 | Shared port input value |

## Verification
Runs with no data requests check the two-fetch pattern against a fresh random fetch address every period. This shows whether the address is taken at the slot-starting edge or at some other edge. Random reads and writes, with random idle gaps, separate the read and write port ownership windows, which differ in periods 4 to 11. A request held across done shows that a data cycle is never followed directly by another. Scrambling the request fields after acceptance shows that they are captured. Address and data extremes (all zeros, all ones) cover the byte lanes of the port and addr_hi.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    // machine cycle geometry
    localparam int PERIODS_PER_STATE = 2;
    localparam int STATES_PER_CYCLE  = 6;
    localparam int CYC_LEN           = PERIODS_PER_STATE * STATES_PER_CYCLE;
    localparam int SLOT_LEN          = CYC_LEN / 2;
    localparam int PH_W              = $clog2(CYC_LEN);

    // data strobe placement relative to the latch pulse
    localparam int STB_OFFSET = 3;
    localparam int STB_LEN    = 6;

    typedef logic [PH_W-1:0] ph_t;

    localparam ph_t PH_LAST     = ph_t'(CYC_LEN - 1);
    localparam ph_t SLOT_LAST   = ph_t'(SLOT_LEN - 1);
    localparam ph_t ALE_LAST    = ph_t'(PERIODS_PER_STATE - 1);
    localparam ph_t STB_FIRST   = ph_t'(PERIODS_PER_STATE + STB_OFFSET);
    localparam ph_t SETUP_LAST  = ph_t'(PERIODS_PER_STATE + STB_OFFSET - 1);
    localparam ph_t STB_LAST    = ph_t'(PERIODS_PER_STATE + STB_OFFSET + STB_LEN - 1);

    typedef enum logic [2:0] {
        ST_F_ALE,
        ST_F_HOLD,
        ST_F_CODE,
        ST_D_ALE,
        ST_D_HOLD,
        ST_D_SETUP,
        ST_D_STROBE,
        ST_D_END
    } bus_st_t;

endpackage

// File: rtl/xbus_phase.sv
module xbus_phase
    import xbus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output ph_t  ph,
    output ph_t  sph
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= '0;
            sph <= '0;
        end else begin
            if (ph == PH_LAST) ph <= '0;
            else               ph <= ph + ph_t'(1);
            if (sph == SLOT_LAST) sph <= '0;
            else                  sph <= sph + ph_t'(1);
        end
    end

endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ph_t     ph,
    input  ph_t     sph,
    input  logic    req,
    input  logic    we_q,
    output bus_st_t st,
    output logic    accept,
    output logic    ale,
    output logic    psen_n,
    output logic    rd_n,
    output logic    wr_n
);

    bus_st_t nx;

    assign accept = (st == ST_F_CODE) && (ph == PH_LAST) && req;

    always_comb begin
        nx = st;
        unique case (st)
            ST_F_ALE:    if (sph == ALE_LAST) nx = ST_F_HOLD;
            ST_F_HOLD:   nx = ST_F_CODE;
            ST_F_CODE:   if (sph == SLOT_LAST) nx = accept ? ST_D_ALE : ST_F_ALE;
            ST_D_ALE:    if (ph == ALE_LAST) nx = ST_D_HOLD;
            ST_D_HOLD:   nx = ST_D_SETUP;
            ST_D_SETUP:  if (ph == SETUP_LAST) nx = ST_D_STROBE;
            ST_D_STROBE: if (ph == STB_LAST) nx = ST_D_END;
            ST_D_END:    nx = ST_F_ALE;
            default:     nx = ST_F_ALE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_F_ALE;
        else     st <= nx;
    end

    // strobe outputs
    always_comb begin
        ale    = 1'b0;
        psen_n = 1'b1;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        unique case (st)
            ST_F_ALE, ST_D_ALE: ale = 1'b1;
            ST_F_CODE:          psen_n = 1'b0;
            ST_D_STROBE: begin
                rd_n = we_q;
                wr_n = ~we_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_st_t           st,
    input  ph_t               ph,
    input  ph_t               sph,
    input  logic              accept,
    input  logic [ADDR_W-1:0] code_addr,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] port_in,
    output logic              we_q,
    output logic [HI_W-1:0]   addr_hi,
    output logic [DATA_W-1:0] port_out,
    output logic              port_oe,
    output logic [DATA_W-1:0] code_byte,
    output logic              code_valid,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    logic [ADDR_W-1:0] fa_q;
    logic [ADDR_W-1:0] da_q;
    logic [DATA_W-1:0] wd_q;

    // fetch address taken at every slot boundary
    always_ff @(posedge clk) begin
        if (rst)                    fa_q <= '0;
        else if (sph == SLOT_LAST)  fa_q <= code_addr;
    end

    // request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            da_q <= '0;
            wd_q <= '0;
            we_q <= 1'b0;
        end else if (accept) begin
            da_q <= req_addr;
            wd_q <= req_wdata;
            we_q <= req_we;
        end
    end

    // returned bytes
    always_ff @(posedge clk) begin
        if (rst) begin
            code_byte  <= '0;
            code_valid <= 1'b0;
            rdata      <= '0;
            done       <= 1'b0;
        end else begin
            code_valid <= (st == ST_F_CODE) && (sph == SLOT_LAST);
            if ((st == ST_F_CODE) && (sph == SLOT_LAST)) code_byte <= port_in;
            done <= (st == ST_D_STROBE) && (ph == STB_LAST);
            if ((st == ST_D_STROBE) && (ph == STB_LAST) && !we_q) rdata <= port_in;
        end
    end

    // shared port and high byte
    always_comb begin
        port_oe  = 1'b0;
        port_out = fa_q[DATA_W-1:0];
        addr_hi  = fa_q[ADDR_W-1:DATA_W];
        unique case (st)
            ST_F_ALE, ST_F_HOLD: port_oe = 1'b1;
            ST_F_CODE:           port_oe = 1'b0;
            ST_D_ALE, ST_D_HOLD: begin
                port_oe  = 1'b1;
                port_out = da_q[DATA_W-1:0];
                addr_hi  = da_q[ADDR_W-1:DATA_W];
            end
            ST_D_SETUP: begin
                port_oe  = 1'b1;
                port_out = (we_q && ph == SETUP_LAST) ? wd_q : da_q[DATA_W-1:0];
                addr_hi  = da_q[ADDR_W-1:DATA_W];
            end
            ST_D_STROBE, ST_D_END: begin
                port_oe  = we_q;
                port_out = we_q ? wd_q : da_q[DATA_W-1:0];
                addr_hi  = da_q[ADDR_W-1:DATA_W];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] code_addr,
    output logic [DATA_W-1:0] code_byte,
    output logic              code_valid,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [HI_W-1:0]   addr_hi,
    output logic [DATA_W-1:0] port_out,
    output logic              port_oe,
    input  logic [DATA_W-1:0] port_in
);

    ph_t     ph;
    ph_t     sph;
    bus_st_t st;
    logic    accept;
    logic    we_q;

    xbus_phase u_phase (
        .clk (clk),
        .rst (rst),
        .ph  (ph),
        .sph (sph)
    );

    xbus_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .ph     (ph),
        .sph    (sph),
        .req    (req),
        .we_q   (we_q),
        .st     (st),
        .accept (accept),
        .ale    (ale),
        .psen_n (psen_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n)
    );

    xbus_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk        (clk),
        .rst        (rst),
        .st         (st),
        .ph         (ph),
        .sph        (sph),
        .accept     (accept),
        .code_addr  (code_addr),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .port_in    (port_in),
        .we_q       (we_q),
        .addr_hi    (addr_hi),
        .port_out   (port_out),
        .port_oe    (port_oe),
        .code_byte  (code_byte),
        .code_valid (code_valid),
        .rdata      (rdata),
        .done       (done)
    );

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ale,
    input logic              psen_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              port_oe,
    input logic [DATA_W-1:0] port_out,
    input logic              done
);

    logic [3:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst)                   low_cnt <= '0;
        else if (!rd_n || !wr_n)   low_cnt <= low_cnt + 4'd1;
        else                       low_cnt <= '0;
    end

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

    a_r2_ale_width: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> ale ##1 !ale);

    a_r3_psen_after_ale: assert property (@(posedge clk) disable iff (rst)
        $fell(psen_n) |-> (!$past(ale) && $past(ale, 2)));

    a_r8_rd_float: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !port_oe);

    a_r9_wr_drive: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> port_oe);

    a_r9_wr_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> (port_oe && $stable(port_out)));

    a_r8_strobe_width: assert property (@(posedge clk) disable iff (rst)
        (rd_n && wr_n && low_cnt != 4'd0) |-> (low_cnt == 4'd6));

    a_r8_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(!rd_n || !wr_n) && rd_n && wr_n));

endmodule

bind xbus_seq xbus_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ale      (ale),
    .psen_n   (psen_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .port_oe  (port_oe),
    .port_out (port_out),
    .done     (done)
);

// File: tb/xbus_seq_test.sv
module xbus_seq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] code_addr = 16'h0;
    logic [7:0]  code_byte;
    logic        code_valid;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        done;
    logic [7:0]  rdata;
    logic        ale, psen_n, rd_n, wr_n, port_oe;
    logic [7:0]  addr_hi, port_out, port_in;
    logic [7:0]  lat = 8'h0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit scram = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_seq uut (
        .clk(clk), .rst(rst), .code_addr(code_addr), .code_byte(code_byte),
        .code_valid(code_valid), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .rdata(rdata), .ale(ale),
        .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr_hi),
        .port_out(port_out), .port_oe(port_oe), .port_in(port_in)
    );

    function automatic logic [7:0] code_f(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] data_f(input logic [15:0] a);
        return (a[7:0] * 8'd3) + a[15:8] + 8'h5A;
    endfunction

    // external address latch and memory
    always @(negedge ale) lat <= port_out;

    always_comb begin
        if (!psen_n)    port_in = code_f({addr_hi, lat});
        else if (!rd_n) port_in = data_f({addr_hi, lat});
        else            port_in = 8'hE7;
    end

    // bench timing model
    int          ph_m = 0;
    bit          dcyc_m = 0;
    bit          run_m = 0;
    logic        we_m = 1'b0;
    logic [15:0] a_m = 16'h0;
    logic [15:0] fa_m = 16'h0;
    logic [7:0]  wd_m = 8'h0;
    bit          cv_e = 0;
    bit          dn_e = 0;
    logic [7:0]  cb_e = 8'h0;
    logic [7:0]  rd_e = 8'h0;

    always @(posedge clk) begin
        if (rst) begin
            ph_m <= 0; dcyc_m <= 0; fa_m <= 16'h0; cv_e <= 0; dn_e <= 0; run_m <= 0;
        end else begin
            run_m <= 1;
            cv_e  <= ((ph_m % 6) == 5) && !dcyc_m;
            cb_e  <= code_f(fa_m);
            dn_e  <= dcyc_m && (ph_m == 10);
            if (dcyc_m && ph_m == 10 && !we_m) rd_e <= data_f(a_m);
            if ((ph_m % 6) == 5) fa_m <= code_addr;
            if (ph_m == 11) begin
                ph_m <= 0;
                if (!dcyc_m && req) begin
                    dcyc_m <= 1; we_m <= req_we; a_m <= req_addr; wd_m <= req_wdata;
                end else begin
                    dcyc_m <= 0;
                end
            end else begin
                ph_m <= ph_m + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s period %0d: actual %0h expected %0h", tag, ph_m, act, exp);
        end
    endtask

    // per-period pin checks
    always @(negedge clk) begin : pin_chk
        int s;
        logic e_ale, e_psen, e_rd, e_wr, e_oe;
        logic [7:0] e_lo, e_hi;
        string t;
        if (run_m && !finished) begin
            s = ph_m % 6;
            if (!dcyc_m) begin
                e_ale = (s < 2); e_psen = !(s >= 3); e_rd = 1'b1; e_wr = 1'b1;
                e_oe = (s <= 2); e_lo = fa_m[7:0]; e_hi = fa_m[15:8]; t = "R4";
            end else begin
                e_ale = (ph_m < 2); e_psen = 1'b1;
                e_rd = !(!we_m && ph_m >= 5 && ph_m <= 10);
                e_wr = !(we_m && ph_m >= 5 && ph_m <= 10);
                e_oe = we_m ? 1'b1 : (ph_m <= 4);
                e_lo = (we_m && ph_m >= 4) ? wd_m : a_m[7:0];
                e_hi = a_m[15:8];
                t = scram ? "R11" : (we_m ? "R9" : "R8");
            end
            chk(dcyc_m ? "R7" : "R2", ale, e_ale);
            chk(ph_m == 3 ? "R6" : (dcyc_m ? "R7" : "R3"), psen_n, e_psen);
            chk("R8", rd_n, e_rd);
            chk("R9", wr_n, e_wr);
            chk(t, port_oe, e_oe);
            if (e_oe) chk(t, port_out, e_lo);
            chk(t, addr_hi, e_hi);
            chk("R10", 32'((!psen_n) + (!rd_n) + (!wr_n) <= 1), 32'd1);
            chk("R5", code_valid, cv_e);
            if (cv_e) chk("R5", code_byte, cb_e);
            chk(we_m ? "R9" : "R8", done, dn_e);
            if (dn_e && !we_m) chk(scram ? "R11" : "R8", rdata, rd_e);
        end
    end

    // random fetch addresses
    initial begin
        forever begin
            @(negedge clk);
            code_addr = rst ? 16'h0 : 16'($urandom);
        end
    end

    task automatic do_access(input logic we, input logic [15:0] a, input logic [7:0] d,
                             input bit scramble, input bit keep);
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        while (!dcyc_m) @(negedge clk);
        if (scramble) begin
            scram = 1;
            req_we = ~we; req_addr = ~a; req_wdata = ~d;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        scram = 0;
        if (!keep) req = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", ale, 1'b1);
        chk("R1", psen_n, 1'b1);
        chk("R1", rd_n, 1'b1);
        chk("R1", wr_n, 1'b1);
        chk("R1", done, 1'b0);
        chk("R1", code_valid, 1'b0);
        rst = 1'b0;
        // fetch-only stretch
        repeat (60) @(negedge clk);
        // directed corners
        do_access(1'b0, 16'h0000, 8'h00, 0, 0);
        do_access(1'b1, 16'hFFFF, 8'hFF, 0, 0);
        do_access(1'b1, 16'h0000, 8'h00, 0, 1);  // R6: request kept high
        do_access(1'b0, 16'hFFFF, 8'h00, 0, 0);
        do_access(1'b0, 16'h12C4, 8'h00, 1, 0);  // R11 scrambled read
        do_access(1'b1, 16'hA35B, 8'h6D, 1, 0);  // R11 scrambled write
        for (int i = 0; i < 200; i++) begin
            repeat ($urandom % 20) @(negedge clk);
            do_access(1'($urandom), 16'($urandom), 8'($urandom), ($urandom % 4) == 0,
                      ($urandom % 3) == 0);
        end
        req = 1'b0;
        repeat (30) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule